// File: doc/BRIEF.md
# Asynchronous Event Reporting Queue

This block sits beside an admin command processor. Controller events come in, and host event-request commands park in the block until an event can be reported. Each event carries a type code, an info byte and a log-page identifier. Accepted events wait in a small ordered store. Request tags wait in a small stack.

On each cycle the block looks through the store from oldest to newest. It takes the first event whose type is not masked and pairs it with the newest outstanding request tag. The pair goes out as a completion record with a success status. Delivering an event masks its type. The type stays masked until the host clears it, usually as a side effect of reading the matching log page. Clearing a type lets any waiting events of that type be reported again. Events of a masked type stay where they are, and newer events of other types can overtake them.

The completion leaves on a valid/ready handshake. The completion register holds its contents while ready is low. No new pairing is made until that register is free or is being drained in the same cycle.

Top module: `aer_queue`

## Requirements
- R1: After reset the store and tag stack are empty and all type masks are clear: `cpl_valid` and `rq_err` are low, and a later event plus request are reported at once.
- R2: The store holds at most `DEPTH` (8) events. An event pushed while the store is full is discarded and is never reported.
- R3: Eligible events are reported oldest first, at most one per cycle. A completion appears on `cpl_valid` two rising edges after the pushed input that makes it possible.
- R4: No completion is produced while no request tag is outstanding. Events then stay stored.
- R5: An event whose type is masked stays in the store and is skipped, while later events of unmasked types are reported past it.
- R6: Reporting an event sets the mask bit of its type. Further events of that type are held back until that type is cleared.
- R7: Request tags are used last-in-first-out: the most recently accepted tag is paired with the next report.
- R8: A completion carries the request tag, the event type, info and log-page byte exactly as pushed, and `cpl_status` = 0 (success).
- R9: A clear of type T resets mask bit T. Stored events of type T become eligible and are reported if tags are outstanding.
- R10: The stack holds at most `TAGS` (4) tags. A request pushed while the stack is full is discarded, and `rq_err` is high for the cycle after that push edge.
- R11: While `cpl_valid` is high and `cpl_ready` is low, the completion outputs hold steady and nothing is removed from the store or stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_push | input | 1 | Event push strobe |
| ev_type | input | TW (3) | Event type code |
| ev_info | input | INFO_W (8) | Event info byte |
| ev_log | input | LOG_W (8) | Associated log-page identifier |
| rq_push | input | 1 | Host event-request arrival strobe |
| rq_tag | input | GW (8) | Tag of the arriving request |
| rq_err | output | 1 | Pulse: request rejected, tag stack full |
| clr_en | input | 1 | Clear strobe for one event type |
| clr_type | input | TW (3) | Type whose mask bit is cleared |
| cpl_valid | output | 1 | Completion record valid |
| cpl_ready | input | 1 | Completion consumer ready |
| cpl_tag | output | GW (8) | Tag of the completed request |
| cpl_type | output | TW (3) | Reported event type |
| cpl_info | output | INFO_W (8) | Reported info byte |
| cpl_log | output | LOG_W (8) | Reported log-page identifier |
| cpl_status | output | 4 | Completion status, 0 = success |

## Verification
Input strobes are captured on one edge. The store or stack changes there and the pairing logic sees the new state right away. The completion register loads on the next edge, so a completion shows on the second edge after its cause, and `rq_err` shows one edge after the rejected push. The bench drives inputs just after a rising edge and samples on falling edges, checking those exact cycles in a directed latency and stall case. In the random phase, each stimulus is followed by a quiet window in which ready toggles before it is held high. The bench model drains its expected completions in order during that window, and the window must end with nothing pending.

// File: rtl/aer_queue.sv
module aer_queue #(
  parameter int DEPTH  = 8,
  parameter int TAGS   = 4,
  parameter int TW     = 3,
  parameter int INFO_W = 8,
  parameter int LOG_W  = 8,
  parameter int GW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_push,
  input  logic [TW-1:0]     ev_type,
  input  logic [INFO_W-1:0] ev_info,
  input  logic [LOG_W-1:0]  ev_log,
  input  logic              rq_push,
  input  logic [GW-1:0]     rq_tag,
  output logic              rq_err,
  input  logic              clr_en,
  input  logic [TW-1:0]     clr_type,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [GW-1:0]     cpl_tag,
  output logic [TW-1:0]     cpl_type,
  output logic [INFO_W-1:0] cpl_info,
  output logic [LOG_W-1:0]  cpl_log,
  output logic [3:0]        cpl_status
);
  localparam int NT = 1 << TW;
  localparam int EW = TW + INFO_W + LOG_W;
  localparam int SI = $clog2(DEPTH);
  localparam int SC = $clog2(DEPTH + 1);
  localparam int TI = $clog2(TAGS);
  localparam int TC = $clog2(TAGS + 1);

  logic [EW-1:0] st [DEPTH];
  logic [SC-1:0] st_cnt;
  logic [GW-1:0] tg [TAGS];
  logic [TC-1:0] tg_cnt;
  logic [NT-1:0] mask;
  logic          found;
  logic [SI-1:0] sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!found && (SC'(i) < st_cnt) && !mask[st[i][EW-1 -: TW]]) begin
        found = 1'b1;
        sel   = SI'(i);
      end
  end

  wire [TW-1:0] sel_type = st[sel][EW-1 -: TW];
  wire          take     = found && (tg_cnt != '0) && (!cpl_valid || cpl_ready);
  wire          ev_ok    = ev_push && (st_cnt != SC'(DEPTH));
  wire          rq_ok    = rq_push && (tg_cnt != TC'(TAGS));
  wire [TI-1:0] top      = TI'(tg_cnt - TC'(1));
  wire [SI-1:0] ev_slot  = SI'(st_cnt - SC'(take));
  wire [TI-1:0] rq_slot  = TI'(tg_cnt - TC'(take));
  wire [NT-1:0] clr_bits = clr_en ? (NT'(1) << clr_type) : '0;
  wire [NT-1:0] set_bits = take ? (NT'(1) << sel_type) : '0;

  assign cpl_status = 4'd0;

  always_ff @(posedge clk) begin
    if (take)
      for (int i = 0; i < DEPTH - 1; i++)
        if (i >= int'(sel)) st[i] <= st[i+1];
    if (ev_ok) st[ev_slot] <= {ev_type, ev_info, ev_log};
    if (rq_ok) tg[rq_slot] <= rq_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_cnt    <= '0;
      tg_cnt    <= '0;
      mask      <= '0;
      rq_err    <= 1'b0;
      cpl_valid <= 1'b0;
      cpl_tag   <= '0;
      cpl_type  <= '0;
      cpl_info  <= '0;
      cpl_log   <= '0;
    end else begin
      st_cnt <= st_cnt + SC'(ev_ok) - SC'(take);
      tg_cnt <= tg_cnt + TC'(rq_ok) - TC'(take);
      mask   <= (mask & ~clr_bits) | set_bits;
      rq_err <= rq_push && !rq_ok;
      if (take) begin
        cpl_valid                     <= 1'b1;
        cpl_tag                       <= tg[top];
        {cpl_type, cpl_info, cpl_log} <= st[sel];
      end else if (cpl_ready) begin
        cpl_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aer_queue_chk.sv
module aer_queue_chk #(
  parameter int DEPTH  = 8,
  parameter int TAGS   = 4,
  parameter int TW     = 3,
  parameter int INFO_W = 8,
  parameter int LOG_W  = 8,
  parameter int GW     = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cpl_valid,
  input logic                         cpl_ready,
  input logic [GW-1:0]                cpl_tag,
  input logic [TW-1:0]                cpl_type,
  input logic [INFO_W-1:0]            cpl_info,
  input logic [LOG_W-1:0]             cpl_log,
  input logic                         rq_push,
  input logic                         rq_err,
  input logic [$clog2(DEPTH+1)-1:0]   st_cnt,
  input logic [$clog2(TAGS+1)-1:0]    tg_cnt,
  input logic [(1<<TW)-1:0]           mask
);
  // R2
  store_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_cnt <= ($clog2(DEPTH+1))'(DEPTH));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_tag) && $stable(cpl_type)
                                && $stable(cpl_info) && $stable(cpl_log));

  // R4
  no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpl_valid || cpl_ready) && tg_cnt == '0 |=> !cpl_valid);

  // R6
  self_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpl_valid) |-> mask[cpl_type]);

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_err |-> $past(rq_push) && $past(tg_cnt) == ($clog2(TAGS+1))'(TAGS));
endmodule

bind aer_queue aer_queue_chk #(
  .DEPTH(DEPTH), .TAGS(TAGS), .TW(TW), .INFO_W(INFO_W), .LOG_W(LOG_W), .GW(GW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
  .cpl_tag(cpl_tag), .cpl_type(cpl_type), .cpl_info(cpl_info), .cpl_log(cpl_log),
  .rq_push(rq_push), .rq_err(rq_err), .st_cnt(st_cnt), .tg_cnt(tg_cnt), .mask(mask)
);

// File: tb/aer_queue_tb.sv
`timescale 1ns/1ps
module aer_queue_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_push = 1'b0, rq_push = 1'b0, clr_en = 1'b0, cpl_ready = 1'b1;
  logic [2:0] ev_type = '0, clr_type = '0, cpl_type;
  logic [7:0] ev_info = '0, ev_log = '0, rq_tag = '0;
  logic [7:0] cpl_tag, cpl_info, cpl_log;
  logic [3:0] cpl_status;
  logic       rq_err, cpl_valid;

  always #2.5 clk = ~clk;

  aer_queue dut_i (
    .clk(clk), .rst_n(rst_n), .ev_push(ev_push), .ev_type(ev_type), .ev_info(ev_info),
    .ev_log(ev_log), .rq_push(rq_push), .rq_tag(rq_tag), .rq_err(rq_err),
    .clr_en(clr_en), .clr_type(clr_type), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_tag(cpl_tag), .cpl_type(cpl_type), .cpl_info(cpl_info), .cpl_log(cpl_log),
    .cpl_status(cpl_status)
  );

  int vecs = 0, errs = 0;
  logic [18:0] m_ev [$];
  logic [7:0]  m_tags [$];
  logic [7:0]  m_mask = '0;
  logic [26:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void settle();
    bit more = 1'b1;
    while (more && m_tags.size() > 0) begin
      int k = -1;
      for (int i = 0; i < m_ev.size(); i++)
        if (k < 0 && !m_mask[m_ev[i][18:16]]) k = i;
      if (k < 0) more = 1'b0;
      else begin
        exp_q.push_back({m_tags[m_tags.size()-1], m_ev[k]});
        m_mask[m_ev[k][18:16]] = 1'b1;
        void'(m_tags.pop_back());
        m_ev.delete(k);
      end
    end
  endfunction

  always @(negedge clk) begin
    if (rst_n && cpl_valid && cpl_ready) begin
      logic [26:0] act;
      act = {cpl_tag, cpl_type, cpl_info, cpl_log};
      if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected completion", 32'(act), 0);
      else begin
        logic [26:0] e;
        e = exp_q.pop_front();
        chk(act == e, "R8", "completion record", 32'(act), 32'(e));
        chk(cpl_status == 4'd0, "R8", "status", 32'(cpl_status), 0);
      end
    end
  end

  task automatic push_ev(input logic [2:0] t, input logic [7:0] inf, input logic [7:0] lg);
    @(posedge clk); #1;
    ev_push = 1'b1; ev_type = t; ev_info = inf; ev_log = lg;
    @(posedge clk); #1;
    ev_push = 1'b0;
    if (m_ev.size() < 8) m_ev.push_back({t, inf, lg});
    settle();
  endtask

  task automatic push_rq(input logic [7:0] tag);
    bit full;
    full = (m_tags.size() == 4);
    @(posedge clk); #1;
    rq_push = 1'b1; rq_tag = tag;
    @(posedge clk); #1;
    rq_push = 1'b0;
    if (!full) m_tags.push_back(tag);
    settle();
    @(negedge clk);
    chk(rq_err == full, "R10", "reject pulse", 32'(rq_err), 32'(full));
  endtask

  task automatic do_clr(input logic [2:0] t);
    @(posedge clk); #1;
    clr_en = 1'b1; clr_type = t;
    @(posedge clk); #1;
    clr_en = 1'b0;
    m_mask[t] = 1'b0;
    settle();
  endtask

  task automatic gap(input int n, input bit rnd, input string req);
    repeat (n) begin
      @(posedge clk); #1;
      cpl_ready = rnd ? 1'($urandom % 2) : 1'b1;
    end
    @(posedge clk); #1;
    cpl_ready = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, req, "pending expected completions", 32'(exp_q.size()), 0);
    chk(!cpl_valid, req, "valid after drain", 32'(cpl_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [26:0] held;
    void'($urandom(32'd7351));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!cpl_valid, "R1", "valid after reset", 32'(cpl_valid), 0);
    chk(!rq_err, "R1", "err after reset", 32'(rq_err), 0);

    // R3 latency and R11 stall
    push_rq(8'h55);
    cpl_ready = 1'b0;
    push_ev(3'd6, 8'hA1, 8'h02);
    @(negedge clk);
    chk(!cpl_valid, "R3", "valid one edge after push", 32'(cpl_valid), 0);
    @(negedge clk);
    chk(cpl_valid, "R3", "valid two edges after push", 32'(cpl_valid), 1);
    held = {cpl_tag, cpl_type, cpl_info, cpl_log};
    repeat (4) @(negedge clk);
    chk(cpl_valid && {cpl_tag, cpl_type, cpl_info, cpl_log} == held, "R11", "hold while stalled",
        32'({cpl_tag, cpl_type, cpl_info, cpl_log}), 32'(held));
    @(posedge clk); #1 cpl_ready = 1'b1;
    gap(2, 1'b0, "R11");

    // R4: events wait without requests
    push_ev(3'd1, 8'h11, 8'h01);
    push_ev(3'd2, 8'h22, 8'h02);
    push_ev(3'd3, 8'h33, 8'h03);
    gap(3, 1'b0, "R4");
    // R7 LIFO tags, R3 oldest first
    push_rq(8'hA0);
    push_rq(8'hB0);
    gap(2, 1'b0, "R7");
    push_rq(8'hC0);
    gap(2, 1'b0, "R3");
    // R5 masked type skipped, R6 self mask
    push_ev(3'd1, 8'h44, 8'h04);
    push_rq(8'hD0);
    gap(2, 1'b0, "R6");
    push_ev(3'd5, 8'h55, 8'h05);
    gap(2, 1'b0, "R5");
    // R9 clear releases held event
    push_rq(8'hE0);
    do_clr(3'd1);
    gap(2, 1'b0, "R9");
    // R2 overflow drop
    for (int t = 0; t < 8; t++) do_clr(3'(t));
    for (int t = 0; t < 8; t++) push_ev(3'(t), 8'(8'h80 + t), 8'(t));
    push_ev(3'd0, 8'hEE, 8'hEE);
    gap(2, 1'b0, "R2");
    for (int t = 0; t < 8; t++) begin push_rq(8'(8'h10 + t)); gap(1, 1'b0, "R2"); end
    do_clr(3'd0);
    push_rq(8'h99);
    gap(2, 1'b0, "R2");
    // R10 stack full
    for (int t = 0; t < 8; t++) begin push_ev(3'd0, 8'h01, 8'h01); end
    for (int t = 0; t < 5; t++) push_rq(8'(8'h60 + t));
    gap(2, 1'b0, "R10");

    // random phase
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 4) push_ev(3'($urandom), 8'($urandom), 8'($urandom));
      else if (r < 7) push_rq(8'($urandom));
      else do_clr(3'($urandom));
      gap(int'($urandom % 4), 1'b1, "R3");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule